// File: doc/BRIEF.md
# Programmable XOR Logic Array

This block is a cycle-based model of a small fuse-programmed logic device. A fuse map configures a programmable AND plane of 40 product terms over 40 literal columns, and ten output macrocells. Each macrocell takes four of those terms and turns them into one output pin. A cell can be registered or combinatorial, and it can use a plain OR sum or an exclusive-OR of two pair sums. A polarity fuse on each cell and a single device-wide mode fuse complete the configuration. The mode fuse decides whether the clock pin and the shared output-enable pin also act as logic inputs. It also decides whether the two end cells feed back into the plane.

The fuse map is written one bit at a time through a parallel port while the device is held inactive. A 40-bit user signature, stored in the same map, can be read one byte at a time. The pins are modelled as separate value and enable vectors. `io_in` carries the level seen on each pin, and that level is what a combinatorial cell feeds back. The register clock pin is sampled by the system clock, and a rising level on it loads the registered cells.

Top module: `xpld_array`

## Requirements
- R1: After reset every fuse reads as intact (1). The device is then in input mode, every `io_oe` bit is 0, and every signature byte reads 8'hFF.
- R2: A fuse write takes effect only when `cfg_en` and `cfg_we` are both 1. While `cfg_en` is 1, every `io_oe` bit is 0 and no cell register changes.
- R3: Product term r is the AND of the literals whose fuse at address 40*r+j is intact (1). Column 2k is plane signal k and column 2k+1 is its complement. A term whose 40 fuses are all intact is 0. Cell c uses terms 4c to 4c+3.
- R4: With the mode fuse (address 1630) at 0, plane signals 0 to 9 are `in_pins[9:0]` and signal 10+c is the feedback of cell c, for all ten cells.
- R5: With the mode fuse at 1, signal 10 is `ck_pin`, signal 19 is `oe_pin_n`, and signals 11 to 18 are the feedbacks of cells 1 to 8. Cells 0 and 9 do not reach the plane.
- R6: A registered cell feeds back its register state. A combinatorial cell feeds back `io_in[c]`.
- R7: Cell c reads its polarity from fuse 1600+c, its arch-low bit from fuse 1610+c and its arch-high bit from fuse 1620+c. The architecture code is {high, low}.
- R8: Code 2'b01 is the registered sum. The register loads t0|t1|t2, `io_out` is the register XOR polarity, and `io_oe` is t3.
- R9: Code 2'b00 is the registered exclusive-OR. The register loads (t0|t1)^(t2|t3), `io_out` is the inverted register, and `io_oe` is the inverse of `oe_pin_n`.
- R10: Code 2'b10 is the combinatorial exclusive-OR. `io_out` is the inverse of (t0|t1)^(t2|t3), and `io_oe` is the inverse of `oe_pin_n`.
- R11: Code 2'b11 is the combinatorial sum. `io_out` is (t0|t1|t2) XOR polarity, and `io_oe` is t3.
- R12: Cell registers reset to 0. A registered cell loads on a `clk` edge at which `ck_pin` is 1, provided it was 0 at the previous edge and `cfg_en` is 0. At all other edges it holds.
- R13: `sig_byte` for `sig_sel`=k (k from 0 to 4) has bit b equal to fuse 1670-8k-b. Select values 5 to 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples the clock pin and writes fuses |
| rst_n | input | 1 | Active-low reset |
| cfg_en | input | 1 | Holds the device inactive and opens the fuse port |
| cfg_we | input | 1 | Fuse write strobe |
| cfg_addr | input | 11 | Fuse address |
| cfg_data | input | 1 | Fuse value to write (1 = intact) |
| in_pins | input | 10 | Dedicated logic inputs |
| ck_pin | input | 1 | Register clock pin, also a logic input in input mode |
| oe_pin_n | input | 1 | Shared active-low enable for the exclusive-OR cells, also a logic input in input mode |
| io_in | input | 10 | Level observed on each output pin |
| io_out | output | 10 | Value each cell drives on its pin |
| io_oe | output | 10 | Drive enable of each pin |
| sig_sel | input | 3 | Signature byte select |
| sig_byte | output | 8 | Selected signature byte |

## Verification
The bound checker watches four things on every cycle. Registers must hold except on a qualified clock-pin rise. The exclusive-OR cells must follow the shared enable pin. The output of each registered cell must agree with its register and polarity. Out-of-range signature selects must read 0. The bench's scenarios are needed for the rest. These include the AND plane and its literal columns, and the signal map that changes with the mode fuse, including how the two end cells drop out. They also include the value each cell loads, feedback from the pin level, and the signature bit order. The bench checks these against its own model of the fuse image, using random sparse maps together with directed single-literal rows.

// File: rtl/xpld_pkg.sv
package xpld_pkg;

    localparam int TERMS_PER_CELL = 4;
    localparam int BYTE_BITS      = 8;

    // Architecture code formed as {arch-high fuse, arch-low fuse}
    typedef enum logic [1:0] {
        ARCH_XREG  = 2'b00,
        ARCH_REG   = 2'b01,
        ARCH_XCOMB = 2'b10,
        ARCH_COMB  = 2'b11
    } arch_e;

    typedef struct packed {
        logic hi;
        logic lo;
        logic pol;
    } cell_cfg_t;

endpackage

// File: rtl/xpld_fuse_store.sv
module xpld_fuse_store #(
    parameter int TOTAL  = 1671,
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              wr_data,
    output logic [TOTAL-1:0]  fuse
);

    typedef struct packed {
        logic [TOTAL-1:0] bits;
    } store_st_t;

    store_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en && (32'(wr_addr) < TOTAL)) begin
            st_d.bits[wr_addr] = wr_data;
        end
    end

    // Erased state: every fuse intact
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{bits: '1};
        end else begin
            st_q <= st_d;
        end
    end

    assign fuse = st_q.bits;

endmodule

// File: rtl/xpld_and_plane.sv
module xpld_and_plane #(
    parameter int NSIG = 20,
    parameter int NROW = 40,
    localparam int NCOL = 2 * NSIG
) (
    input  logic [NSIG-1:0]      sig,
    input  logic [NROW*NCOL-1:0] plane,
    output logic [NROW-1:0]      terms
);

    logic [NCOL-1:0] lit;

    always_comb begin
        for (int k = 0; k < NSIG; k++) begin
            lit[2*k]     = sig[k];
            lit[2*k + 1] = ~sig[k];
        end
    end

    for (genvar r = 0; r < NROW; r++) begin : g_row
        logic [NCOL-1:0] row;
        logic            all_intact;
        assign row        = plane[r*NCOL +: NCOL];
        assign all_intact = &row;
        assign terms[r]   = (&(~row | lit)) & ~all_intact;
    end

endmodule

// File: rtl/xpld_macrocell.sv
module xpld_macrocell
    import xpld_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      load,
    input  logic [TERMS_PER_CELL-1:0] terms,
    input  cell_cfg_t                 cfg,
    input  logic                      oe_pin_n,
    input  logic                      pin_in,
    output logic                      pin_out,
    output logic                      pin_oe,
    output logic                      fb,
    output logic                      reg_q
);

    typedef struct packed {
        logic q;
    } cell_st_t;

    cell_st_t st_d, st_q;
    arch_e    arch;
    logic     or3;
    logic     xsum;

    always_comb begin
        arch = arch_e'({cfg.hi, cfg.lo});
        or3  = terms[0] | terms[1] | terms[2];
        xsum = (terms[0] | terms[1]) ^ (terms[2] | terms[3]);
        st_d = st_q;
        if (load) begin
            case (arch)
                ARCH_XREG: st_d.q = xsum;
                ARCH_REG:  st_d.q = or3;
                default:   st_d.q = st_q.q;
            endcase
        end
        case (arch)
            ARCH_XREG: begin
                pin_out = ~st_q.q;
                pin_oe  = ~oe_pin_n;
            end
            ARCH_REG: begin
                pin_out = st_q.q ^ cfg.pol;
                pin_oe  = terms[3];
            end
            ARCH_XCOMB: begin
                pin_out = ~xsum;
                pin_oe  = ~oe_pin_n;
            end
            default: begin
                pin_out = or3 ^ cfg.pol;
                pin_oe  = terms[3];
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{q: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    // Combinatorial codes have the high arch bit set and return the pin level
    assign fb    = cfg.hi ? pin_in : st_q.q;
    assign reg_q = st_q.q;

endmodule

// File: rtl/xpld_array.sv
module xpld_array
    import xpld_pkg::*;
#(
    parameter int NUM_IN    = 10,
    parameter int NUM_CELLS = 10,
    parameter int SIG_BYTES = 5,
    localparam int NSIG       = NUM_IN + NUM_CELLS,
    localparam int NCOL       = 2 * NSIG,
    localparam int NROW       = NUM_CELLS * TERMS_PER_CELL,
    localparam int PLANE_BITS = NROW * NCOL,
    localparam int POL_BASE   = PLANE_BITS,
    localparam int LO_BASE    = POL_BASE + NUM_CELLS,
    localparam int HI_BASE    = LO_BASE + NUM_CELLS,
    localparam int MODE_ADDR  = HI_BASE + NUM_CELLS,
    localparam int SIG_BASE   = MODE_ADDR + 1,
    localparam int SIG_BITS   = SIG_BYTES * BYTE_BITS,
    localparam int FUSE_TOTAL = SIG_BASE + SIG_BITS,
    localparam int ADDR_W     = $clog2(FUSE_TOTAL),
    localparam int SEL_W      = $clog2(SIG_BYTES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_en,
    input  logic                 cfg_we,
    input  logic [ADDR_W-1:0]    cfg_addr,
    input  logic                 cfg_data,
    input  logic [NUM_IN-1:0]    in_pins,
    input  logic                 ck_pin,
    input  logic                 oe_pin_n,
    input  logic [NUM_CELLS-1:0] io_in,
    output logic [NUM_CELLS-1:0] io_out,
    output logic [NUM_CELLS-1:0] io_oe,
    input  logic [SEL_W-1:0]     sig_sel,
    output logic [BYTE_BITS-1:0] sig_byte
);

    typedef struct packed {
        logic ck;
    } pin_st_t;

    pin_st_t pin_st_d, pin_st_q;

    logic [FUSE_TOTAL-1:0] fuse;
    logic                  mode_in;
    logic                  ck_prev;
    logic                  load;
    logic [NSIG-1:0]       sig;
    logic [NROW-1:0]       terms;
    logic [SIG_BITS-1:0]   sig_vec;
    logic [NUM_CELLS-1:0]  cell_out, cell_oe, cell_fb, reg_q;
    logic [NUM_CELLS-1:0]  cell_lo, cell_hi, cell_pol;

    xpld_fuse_store #(
        .TOTAL  (FUSE_TOTAL),
        .ADDR_W (ADDR_W)
    ) u_fuse (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_en & cfg_we),
        .wr_addr (cfg_addr),
        .wr_data (cfg_data),
        .fuse    (fuse)
    );

    // Clock pin sampled into the system clock domain
    always_comb begin
        pin_st_d    = pin_st_q;
        pin_st_d.ck = ck_pin;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin_st_q <= '{ck: 1'b0};
        end else begin
            pin_st_q <= pin_st_d;
        end
    end

    assign ck_prev = pin_st_q.ck;
    assign load    = ck_pin & ~ck_prev & ~cfg_en;
    assign mode_in = fuse[MODE_ADDR];

    // Plane signal map; input mode replaces the end-cell slots with pins
    always_comb begin
        sig              = '0;
        sig[NUM_IN-1:0]  = in_pins;
        for (int c = 0; c < NUM_CELLS; c++) begin
            sig[NUM_IN + c] = cell_fb[c];
        end
        if (mode_in) begin
            sig[NUM_IN]   = ck_pin;
            sig[NSIG-1]   = oe_pin_n;
        end
    end

    xpld_and_plane #(
        .NSIG (NSIG),
        .NROW (NROW)
    ) u_plane (
        .sig   (sig),
        .plane (fuse[PLANE_BITS-1:0]),
        .terms (terms)
    );

    for (genvar c = 0; c < NUM_CELLS; c++) begin : g_cell
        cell_cfg_t cfg;
        assign cell_pol[c] = fuse[POL_BASE + c];
        assign cell_lo[c]  = fuse[LO_BASE + c];
        assign cell_hi[c]  = fuse[HI_BASE + c];
        assign cfg         = '{hi: cell_hi[c], lo: cell_lo[c], pol: cell_pol[c]};

        xpld_macrocell u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (load),
            .terms    (terms[c*TERMS_PER_CELL +: TERMS_PER_CELL]),
            .cfg      (cfg),
            .oe_pin_n (oe_pin_n),
            .pin_in   (io_in[c]),
            .pin_out  (cell_out[c]),
            .pin_oe   (cell_oe[c]),
            .fb       (cell_fb[c]),
            .reg_q    (reg_q[c])
        );
    end

    assign io_out = cell_out;
    assign io_oe  = cfg_en ? '0 : cell_oe;

    // Signature: highest fuse address is bit 0 of byte 0
    for (genvar i = 0; i < SIG_BITS; i++) begin : g_sig
        assign sig_vec[i] = fuse[SIG_BASE + SIG_BITS - 1 - i];
    end

    always_comb begin
        sig_byte = '0;
        for (int k = 0; k < SIG_BYTES; k++) begin
            if (sig_sel == SEL_W'(k)) begin
                sig_byte = sig_vec[k*BYTE_BITS +: BYTE_BITS];
            end
        end
    end

endmodule

// File: rtl/xpld_array_chk.sv
module xpld_array_chk #(
    parameter int NUM_CELLS = 10,
    parameter int SIG_BYTES = 5,
    parameter int SEL_W     = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cfg_en,
    input logic                 ck_pin,
    input logic                 ck_prev,
    input logic                 oe_pin_n,
    input logic [NUM_CELLS-1:0] io_out,
    input logic [NUM_CELLS-1:0] io_oe,
    input logic [NUM_CELLS-1:0] reg_q,
    input logic [NUM_CELLS-1:0] cell_lo,
    input logic [NUM_CELLS-1:0] cell_hi,
    input logic [NUM_CELLS-1:0] cell_pol,
    input logic [SEL_W-1:0]     sig_sel,
    input logic [7:0]           sig_byte
);

    // R12 R2
    reg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_en || !(ck_pin && !ck_prev)) |=> $stable(reg_q));

    // R9 R10
    xor_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |-> (((~cell_lo) & (io_oe ^ {NUM_CELLS{~oe_pin_n}})) == '0));

    // R8
    reg_polarity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (((~cell_hi) & cell_lo & (io_out ^ reg_q ^ cell_pol)) == '0));

    // R9
    xreg_invert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (((~cell_hi) & (~cell_lo) & (io_out ^ ~reg_q)) == '0));

    // R13
    sig_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(sig_sel) >= SIG_BYTES) |-> (sig_byte == 8'h00));

    // R1
    reset_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (io_oe == '0));

endmodule

bind xpld_array xpld_array_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_en   (cfg_en),
    .ck_pin   (ck_pin),
    .ck_prev  (ck_prev),
    .oe_pin_n (oe_pin_n),
    .io_out   (io_out),
    .io_oe    (io_oe),
    .reg_q    (reg_q),
    .cell_lo  (cell_lo),
    .cell_hi  (cell_hi),
    .cell_pol (cell_pol),
    .sig_sel  (sig_sel),
    .sig_byte (sig_byte)
);

// File: tb/xpld_array_tb_top.sv
module xpld_array_tb_top;

    localparam int NF = 1671;

    logic       clk = 1'b0;
    logic       rst_n, cfg_en, cfg_we, cfg_data, ck_pin, oe_pin_n;
    logic [10:0] cfg_addr;
    logic [9:0] in_pins, io_in, io_out, io_oe;
    logic [2:0] sig_sel;
    logic [7:0] sig_byte;

    int n_chk = 0;
    int n_bad = 0;
    bit fm [NF];
    bit [9:0] mq;

    always #10 clk = ~clk;

    xpld_array dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_data(cfg_data), .in_pins(in_pins),
        .ck_pin(ck_pin), .oe_pin_n(oe_pin_n), .io_in(io_in),
        .io_out(io_out), .io_oe(io_oe), .sig_sel(sig_sel), .sig_byte(sig_byte)
    );

    task automatic check(string tag, logic [15:0] got, logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    // Bench model of the device from the fuse image
    function automatic void model(output bit [9:0] o, output bit [9:0] e, output bit [9:0] d);
        bit [19:0] s;
        bit [39:0] t;
        s[9:0] = in_pins;
        for (int c = 0; c < 10; c++) s[10+c] = fm[1620+c] ? io_in[c] : mq[c];
        if (fm[1630]) begin
            s[10] = ck_pin;
            s[19] = oe_pin_n;
        end
        for (int r = 0; r < 40; r++) begin
            bit ok = 1'b1;
            bit full = 1'b1;
            for (int j = 0; j < 40; j++) begin
                if (fm[40*r+j]) ok &= (j % 2 == 1) ? ~s[j/2] : s[j/2];
                else full = 1'b0;
            end
            t[r] = ok & ~full;
        end
        for (int c = 0; c < 10; c++) begin
            bit or3 = t[4*c] | t[4*c+1] | t[4*c+2];
            bit xs  = (t[4*c] | t[4*c+1]) ^ (t[4*c+2] | t[4*c+3]);
            bit pol = fm[1600+c];
            case ({fm[1620+c], fm[1610+c]})
                2'b00: begin o[c] = ~mq[c];    e[c] = ~oe_pin_n; d[c] = xs;  end
                2'b01: begin o[c] = mq[c]^pol; e[c] = t[4*c+3];  d[c] = or3; end
                2'b10: begin o[c] = ~xs;       e[c] = ~oe_pin_n; d[c] = mq[c]; end
                default: begin o[c] = or3^pol; e[c] = t[4*c+3];  d[c] = mq[c]; end
            endcase
        end
    endfunction

    task automatic cmp_pins(string tag);
        bit [9:0] o, e, d;
        model(o, e, d);
        check({tag, " out"}, 16'(io_out), 16'(o));
        check({tag, " oe"}, 16'(io_oe), cfg_en ? 16'h0 : 16'(e));
    endtask

    task automatic poke(int a, bit v);
        @(negedge clk);
        cfg_en = 1'b1; cfg_we = 1'b1; cfg_addr = 11'(a); cfg_data = v; fm[a] = v;
        @(negedge clk);
        cfg_we = 1'b0; cfg_en = 1'b0;
    endtask

    task automatic load_image();
        @(negedge clk);
        cfg_en = 1'b1; cfg_we = 1'b1;
        for (int a = 0; a < NF; a++) begin
            cfg_addr = 11'(a); cfg_data = fm[a];
            @(negedge clk);
        end
        cfg_we = 1'b0; cfg_en = 1'b0;
    endtask

    task automatic rand_image(bit syn);
        for (int r = 0; r < 40; r++) begin
            int k;
            for (int j = 0; j < 40; j++) fm[40*r+j] = 1'b0;
            k = int'($urandom_range(2, 0));
            repeat (k) fm[40*r + int'($urandom_range(39, 0))] = 1'b1;
        end
        for (int a = 1600; a < 1630; a++) fm[a] = bit'($urandom_range(1, 0));
        fm[1630] = syn;
        for (int a = 1631; a < NF; a++) fm[a] = bit'($urandom_range(1, 0));
    endtask

    task automatic check_sig(string tag);
        for (int k = 0; k < 8; k++) begin
            bit [7:0] eb = 8'h00;
            if (k < 5) for (int b = 0; b < 8; b++) eb[b] = fm[1670 - 8*k - b];
            sig_sel = 3'(k);
            #1;
            check(tag, 16'(sig_byte), 16'(eb));
        end
    endtask

    // One vector: check outputs, optionally pulse the clock pin
    task automatic vector(string tag, bit pulse);
        bit [9:0] o, e, d;
        @(negedge clk);
        in_pins = 10'($urandom); io_in = 10'($urandom);
        oe_pin_n = bit'($urandom_range(1, 0)); ck_pin = 1'b0;
        #5 cmp_pins(tag);
        if (pulse) begin
            @(negedge clk);
            ck_pin = 1'b1;
            #5 cmp_pins(tag);
            model(o, e, d);
            if (!cfg_en) mq = d;
            @(negedge clk);
            ck_pin = 1'b0;
        end
    endtask

    initial begin
        #(20 * 200000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'hC0FFEE));
        rst_n = 1'b0; cfg_en = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_data = 1'b0;
        in_pins = '0; ck_pin = 1'b0; oe_pin_n = 1'b1; io_in = '0; sig_sel = '0;
        for (int a = 0; a < NF; a++) fm[a] = 1'b1;
        mq = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: erased state after reset
        @(negedge clk);
        check("R1 io_oe after reset", 16'(io_oe), 16'h0);
        check_sig("R1 R13 signature after reset");

        // R2: write while cfg_en is low is ignored
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 11'd1670; cfg_data = 1'b0;
        @(negedge clk);
        cfg_we = 1'b0;
        sig_sel = 3'd0; #1;
        check("R2 write without cfg_en", 16'(sig_byte), 16'h00FF);

        // R3 R11: cell 0 as combinatorial sum, term 3 all blown -> enabled
        poke(1600, 1'b0);
        for (int j = 0; j < 40; j++) poke(3*40 + j, 1'b0);
        @(negedge clk); #5;
        check("R3 R11 all-intact terms give 0", 16'(io_out[0]), 16'h0);
        check("R3 R11 blown term enables", 16'(io_oe[0]), 16'h1);
        poke(1600, 1'b1);
        @(negedge clk); #5;
        check("R11 polarity inverts", 16'(io_out[0]), 16'h1);
        poke(1600, 1'b0);
        for (int j = 0; j < 40; j++) poke(j, 1'b0);
        poke(0, 1'b1);
        for (int v = 0; v < 2; v++) begin
            @(negedge clk); in_pins[0] = 1'(v); #5;
            check("R3 true literal column", 16'(io_out[0]), 16'(v));
        end
        poke(0, 1'b0); poke(1, 1'b1);
        for (int v = 0; v < 2; v++) begin
            @(negedge clk); in_pins[0] = 1'(v); #5;
            check("R3 complement column", 16'(io_out[0]), 16'(1 - v));
        end
        // R5: input mode, column 20 is the clock pin, column 38 the enable pin
        poke(1, 1'b0); poke(20, 1'b1);
        for (int v = 0; v < 2; v++) begin
            @(negedge clk); ck_pin = 1'(v); io_in[0] = 1'(1 - v); #5;
            check("R5 clock pin in plane", 16'(io_out[0]), 16'(v));
        end
        @(negedge clk); ck_pin = 1'b0;
        poke(20, 1'b0); poke(38, 1'b1);
        for (int v = 0; v < 2; v++) begin
            @(negedge clk); oe_pin_n = 1'(v); io_in[9] = 1'(1 - v); #5;
            check("R5 enable pin in plane", 16'(io_out[0]), 16'(v));
        end
        // R4 R6: feedback mode, column 20 is cell 0 pin feedback
        poke(38, 1'b0); poke(20, 1'b1); poke(1630, 1'b0);
        for (int v = 0; v < 2; v++) begin
            @(negedge clk); io_in[0] = 1'(v); ck_pin = 1'(1 - v); #5;
            check("R4 R6 cell feedback in plane", 16'(io_out[0]), 16'(v));
        end
        @(negedge clk); ck_pin = 1'b0;

        // Random sparse maps in both modes (R3 R4 R5 R6 R7 R8 R9 R10 R11 R12)
        for (int p = 0; p < 8; p++) begin
            bit syn = bit'(p % 2);
            rand_image(syn);
            load_image();
            check_sig("R13 signature order");
            for (int n = 0; n < 120; n++) begin
                vector(syn ? "R5 R6 R8 R9 R10 R11 R12 input mode"
                           : "R4 R6 R8 R9 R10 R11 R12 feedback mode",
                       bit'($urandom_range(1, 0)));
            end
            // R2: cfg_en darkens pins and blocks register loads
            @(negedge clk); cfg_en = 1'b1; #5;
            check("R2 cfg_en disables pins", 16'(io_oe), 16'h0);
            vector("R2 R12 pulse while held", 1'b1);
            @(negedge clk); cfg_en = 1'b0; #5;
            cmp_pins("R2 R12 state held through cfg_en");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule